// File: doc/BRIEF.md
# Triangular-Window Filter with Block-Averaging Decimator

This block smooths a stream of signed 16-bit samples and reduces its rate. Each accepted sample passes through two identical running-mean stages whose window length is a power of two. Chaining two equal rectangular windows gives a triangular impulse response. The smoothed stream then feeds a block averager. It collects a power-of-two number of consecutive values and emits one 32-bit result per block. The integer part sits in the upper word. The bits gained by averaging sit at the top of the lower word. A signed 32-bit correction in the same split format is added to every result, and the sum saturates.

Samples enter on a valid/ready handshake and results leave on one. The input side obeys back-pressure. `s_ready` falls while a finished result waits for an unasserted `m_ready`. It also falls for the single cycle in which either exponent control differs from its value on the previous clock. That cycle clears all filter history and the block count, so no sample is lost to a flush. A result stays on `m_data_hi`/`m_data_lo` with `m_valid` high until `m_ready` is seen. The whole filter chain is combinational between the accepted sample and the result register. A result therefore appears on the clock edge that accepts the last sample of its block.

Top module: `bartlett_decimator`

## Requirements
- R1: After reset `m_valid` is 0, all history and the block count are zero, and with both exponent inputs at 0 `s_ready` is 1.
- R2: Each stage outputs the floor (arithmetic shift right by B) of the sum of its last 2^B inputs, with B = `tap_exp`. History cleared by reset or flush counts as zero. A `tap_exp` above 6 acts as 6, so windows range from 1 to 64 taps.
- R3: Two such stages with the same B are cascaded: the second stage averages the outputs of the first.
- R4: The decimator sums 2^D consecutive second-stage values, with D = `dec_exp` and values above 16 acting as 16. It emits exactly one result per 2^D accepted samples, on the clock edge that accepts the last sample of the block.
- R5: Before the correction is added, the 32-bit result equals the block sum shifted left by 16 − D. The upper word is the integer mean at input scale. The D fraction bits occupy the lower word from bit 15 downward, and lower-word bits below them are zero.
- R6: `bias` is added as a signed 32-bit value. The sum saturates to 0x7FFFFFFF or 0x80000000 instead of wrapping.
- R7: In a cycle where `tap_exp` or `dec_exp` differs from its value on the previous clock, `s_ready` is 0. At that edge both stage histories, their sums and the block count return to zero, and a pending result is kept.
- R8: While `m_valid` is 1 and `m_ready` is 0, `s_ready` is 0 and the result holds its value. `m_valid` drops on the edge where `m_ready` is 1 and no new result completes.
- R9: Filter and decimator state advance only on cycles with `s_valid` and `s_ready` both 1. Other cycles leave all state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Input sample valid |
| s_ready | output | 1 | Block can accept a sample this cycle |
| s_sample | input | 16 | Signed input sample |
| tap_exp | input | 3 | Window exponent B, 2^B taps per stage |
| dec_exp | input | 5 | Block exponent D, 2^D samples per result |
| bias | input | 32 | Signed correction added to every result |
| m_valid | output | 1 | Result available |
| m_ready | input | 1 | Consumer takes the result |
| m_data_hi | output | 16 | Upper word of the result: integer mean |
| m_data_lo | output | 16 | Lower word of the result: fraction bits, MSB-justified |

## Verification
An impulse separates the single-stage rectangle from the cascaded triangle, because the triangle spreads the impulse over 2·2^B − 1 outputs with a rising then falling shape. A ramp and full-scale constants expose shift direction, sign extension, fraction placement and saturation of the correction sum at both ends. Random samples under random `s_valid` gaps and random `m_ready` stalls separate correct hold behaviour from state that advances without an accepted sample. Exponents changed in the middle of a block, and out-of-range exponents, show whether a flush really restarts the window and the count and whether the clamp applies.

// File: rtl/bfd_pkg.sv
package bfd_pkg;
  localparam int unsigned SAMPLE_W    = 16;
  localparam int unsigned TAP_EXP_MAX = 6;
  localparam int unsigned DEC_EXP_MAX = 16;
  localparam int unsigned RESULT_W    = 32;
  localparam int unsigned STAGE_COUNT = 2;
  localparam int unsigned TAP_CTRL_W  = 3;
  localparam int unsigned DEC_CTRL_W  = 5;
endpackage

// File: rtl/bfd_boxcar.sv
// Running-mean stage: window of 2^exp taps, circular history sized for the max.
module bfd_boxcar #(
  parameter int unsigned W       = bfd_pkg::SAMPLE_W,
  parameter int unsigned MAX_EXP = bfd_pkg::TAP_EXP_MAX,
  localparam int unsigned EXP_W  = $clog2(MAX_EXP + 1),
  localparam int unsigned DEPTH  = 1 << MAX_EXP,
  localparam int unsigned PTR_W  = (MAX_EXP > 0) ? MAX_EXP : 1,
  localparam int unsigned SUM_W  = W + MAX_EXP
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 flush,
  input  logic                 adv,
  input  logic [EXP_W-1:0]     exp_eff,
  input  logic signed [W-1:0]  x,
  output logic signed [W-1:0]  y
);
  logic signed [W-1:0]     hist [DEPTH];
  logic [PTR_W-1:0]        wr_ptr;
  logic [PTR_W-1:0]        back;
  logic [PTR_W-1:0]        rd_idx;
  logic signed [SUM_W-1:0] sum_q;
  logic signed [SUM_W-1:0] sum_nx;
  logic signed [SUM_W-1:0] y_wide;
  logic signed [W-1:0]     old;

  // 2^exp wraps to 0 at full depth, which reads the slot about to be overwritten.
  assign back   = PTR_W'(1) << exp_eff;
  assign rd_idx = wr_ptr - back;
  assign old    = hist[rd_idx];
  assign sum_nx = sum_q + {{MAX_EXP{x[W-1]}}, x} - {{MAX_EXP{old[W-1]}}, old};
  assign y_wide = sum_nx >>> exp_eff;
  assign y      = y_wide[W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      sum_q  <= '0;
      wr_ptr <= '0;
      for (int i = 0; i < DEPTH; i++) hist[i] <= '0;
    end else if (adv) begin
      sum_q        <= sum_nx;
      hist[wr_ptr] <= x;
      wr_ptr       <= wr_ptr + PTR_W'(1);
    end
  end

  // R2: the mean of in-range samples never leaves the sample range
  a_r2_mean_fits: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> ((&y_wide[SUM_W-1:W-1]) || !(|y_wide[SUM_W-1:W-1])));
endmodule

// File: rtl/bfd_block_avg.sv
// Block averager: sums 2^d values, scales to split format, adds bias, saturates.
module bfd_block_avg #(
  parameter int unsigned W       = bfd_pkg::SAMPLE_W,
  parameter int unsigned MAX_EXP = bfd_pkg::DEC_EXP_MAX,
  parameter int unsigned OUT_W   = bfd_pkg::RESULT_W,
  localparam int unsigned EXP_W  = $clog2(MAX_EXP + 1),
  localparam int unsigned CNT_W  = MAX_EXP + 1,
  localparam int unsigned ACC_W  = W + MAX_EXP + 1,
  localparam int unsigned WIDE_W = OUT_W + 2,
  localparam int unsigned FRAC_W = OUT_W - W,
  localparam int unsigned SH_W   = $clog2(FRAC_W + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    flush,
  input  logic                    adv,
  input  logic [EXP_W-1:0]        d_eff,
  input  logic signed [W-1:0]     x,
  input  logic [OUT_W-1:0]        bias,
  input  logic                    out_take,
  output logic                    out_vld,
  output logic [OUT_W-1:0]        out_res
);
  logic [CNT_W-1:0]         cnt_q;
  logic [CNT_W-1:0]         mask;
  logic signed [ACC_W-1:0]  acc_q;
  logic signed [ACC_W-1:0]  acc_nx;
  logic signed [WIDE_W-1:0] acc_w;
  logic signed [WIDE_W-1:0] scaled;
  logic signed [WIDE_W-1:0] total;
  logic [SH_W-1:0]          shamt;
  logic                     last;
  logic                     fits;
  logic [OUT_W-1:0]         sat_res;

  assign mask   = (CNT_W'(1) << d_eff) - CNT_W'(1);
  assign last   = (cnt_q == mask);
  assign acc_nx = acc_q + {{(ACC_W-W){x[W-1]}}, x};
  assign acc_w  = {{(WIDE_W-ACC_W){acc_nx[ACC_W-1]}}, acc_nx};
  assign shamt  = SH_W'(FRAC_W) - SH_W'(d_eff);
  assign scaled = acc_w <<< shamt;
  assign total  = scaled + {{(WIDE_W-OUT_W){bias[OUT_W-1]}}, bias};
  assign fits   = (&total[WIDE_W-1:OUT_W-1]) || !(|total[WIDE_W-1:OUT_W-1]);

  always_comb begin
    if (fits)                 sat_res = total[OUT_W-1:0];
    else if (total[WIDE_W-1]) sat_res = {1'b1, {(OUT_W-1){1'b0}}};
    else                      sat_res = {1'b0, {(OUT_W-1){1'b1}}};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      acc_q   <= '0;
      out_vld <= 1'b0;
      out_res <= '0;
    end else begin
      if (adv && last) begin
        out_vld <= 1'b1;
        out_res <= sat_res;
      end else if (out_take) begin
        out_vld <= 1'b0;
      end
      if (flush) begin
        cnt_q <= '0;
        acc_q <= '0;
      end else if (adv) begin
        cnt_q <= last ? '0 : cnt_q + CNT_W'(1);
        acc_q <= last ? '0 : acc_nx;
      end
    end
  end

  // R4: the count stays inside the current block length
  a_r4_count_in_block: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |-> (cnt_q <= mask));
endmodule

// File: rtl/bartlett_decimator.sv
module bartlett_decimator #(
  parameter int unsigned W         = bfd_pkg::SAMPLE_W,
  parameter int unsigned TAP_MAX   = bfd_pkg::TAP_EXP_MAX,
  parameter int unsigned DEC_MAX   = bfd_pkg::DEC_EXP_MAX,
  parameter int unsigned OUT_W     = bfd_pkg::RESULT_W,
  parameter int unsigned N_STAGES  = bfd_pkg::STAGE_COUNT,
  parameter int unsigned TAP_CW    = bfd_pkg::TAP_CTRL_W,
  parameter int unsigned DEC_CW    = bfd_pkg::DEC_CTRL_W,
  localparam int unsigned BE_W     = $clog2(TAP_MAX + 1),
  localparam int unsigned DE_W     = $clog2(DEC_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [W-1:0]      s_sample,
  input  logic [TAP_CW-1:0] tap_exp,
  input  logic [DEC_CW-1:0] dec_exp,
  input  logic [OUT_W-1:0]  bias,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [W-1:0]      m_data_hi,
  output logic [W-1:0]      m_data_lo
);
  logic [TAP_CW-1:0]   tap_q;
  logic [DEC_CW-1:0]   dec_q;
  logic                flush;
  logic                adv;
  logic [BE_W-1:0]     b_eff;
  logic [DE_W-1:0]     d_eff;
  logic signed [W-1:0] chain [N_STAGES+1];
  logic [OUT_W-1:0]    res;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tap_q <= '0;
      dec_q <= '0;
    end else begin
      tap_q <= tap_exp;
      dec_q <= dec_exp;
    end
  end

  assign flush   = (tap_exp != tap_q) || (dec_exp != dec_q);
  assign s_ready = !flush && !(m_valid && !m_ready);
  assign adv     = s_valid && s_ready;
  assign b_eff   = (tap_exp > TAP_CW'(TAP_MAX)) ? BE_W'(TAP_MAX) : BE_W'(tap_exp);
  assign d_eff   = (dec_exp > DEC_CW'(DEC_MAX)) ? DE_W'(DEC_MAX) : DE_W'(dec_exp);
  assign chain[0] = s_sample;

  for (genvar g = 0; g < N_STAGES; g++) begin : g_stage
    bfd_boxcar #(.W(W), .MAX_EXP(TAP_MAX)) i_box (
      .clk(clk), .rst_n(rst_n), .flush(flush), .adv(adv),
      .exp_eff(b_eff), .x(chain[g]), .y(chain[g+1])
    );
  end

  bfd_block_avg #(.W(W), .MAX_EXP(DEC_MAX), .OUT_W(OUT_W)) i_dec (
    .clk(clk), .rst_n(rst_n), .flush(flush), .adv(adv),
    .d_eff(d_eff), .x(chain[N_STAGES]), .bias(bias),
    .out_take(m_ready), .out_vld(m_valid), .out_res(res)
  );

  assign m_data_hi = res[OUT_W-1:OUT_W-W];
  assign m_data_lo = res[W-1:0];

  // R8: a stalled result blocks new input
  a_r8_ready_low: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |-> !s_ready);
  // R8: a stalled result holds
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable({m_data_hi, m_data_lo})));
  // R7: a flush cycle never completes a block
  a_r7_flush_no_result: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !$rose(m_valid));
  // R9: a new result needs an accepted sample
  a_r9_result_needs_accept: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_valid) |-> $past(s_valid && s_ready));
endmodule

// File: tb/test_bartlett_decimator.sv
module test_bartlett_decimator;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [15:0] s_sample = '0;
  logic [2:0]  tap_exp = '0;
  logic [4:0]  dec_exp = '0;
  logic [31:0] bias = '0;
  logic        m_valid;
  logic        m_ready = 1'b1;
  logic [15:0] m_data_hi;
  logic [15:0] m_data_lo;

  int    total = 0;
  int    bad = 0;
  string cur_req = "R1";
  bit    finished = 0;

  // reference model state
  longint q1[$];
  longint q2[$];
  int     prev_b = 0;
  int     prev_d = 0;
  longint acc = 0;
  longint cnt = 0;
  bit     ev = 0;
  logic [31:0] ed = '0;

  always #10 clk = ~clk;

  bartlett_decimator i_bartlett_decimator (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_sample(s_sample), .tap_exp(tap_exp), .dec_exp(dec_exp), .bias(bias),
    .m_valid(m_valid), .m_ready(m_ready), .m_data_hi(m_data_hi), .m_data_lo(m_data_lo)
  );

  function automatic longint tail_mean(longint q[$], int n, int sh);
    longint s = 0;
    for (int k = 0; k < n; k++) if (k < q.size()) s += q[q.size()-1-k];
    return s >>> sh;
  endfunction

  function automatic bit model_ready();
    bit fl = (int'(tap_exp) != prev_b) || (int'(dec_exp) != prev_d);
    return !fl && !(ev && !m_ready);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      q1.delete(); q2.delete();
      prev_b = 0; prev_d = 0; acc = 0; cnt = 0; ev = 0; ed = '0;
    end else begin
      automatic bit fl  = (int'(tap_exp) != prev_b) || (int'(dec_exp) != prev_d);
      automatic bit rdy = model_ready();
      automatic int be  = (tap_exp > 6) ? 6 : int'(tap_exp);
      automatic int de  = (dec_exp > 16) ? 16 : int'(dec_exp);
      if (ev && m_ready) ev = 0;
      if (fl) begin
        q1.delete(); q2.delete(); acc = 0; cnt = 0;
      end else if (s_valid && rdy) begin
        automatic longint y1, y2, r;
        q1.push_back(longint'($signed(s_sample)));
        if (q1.size() > 64) void'(q1.pop_front());
        y1 = tail_mean(q1, 1 << be, be);
        q2.push_back(y1);
        if (q2.size() > 64) void'(q2.pop_front());
        y2 = tail_mean(q2, 1 << be, be);
        acc += y2;
        cnt++;
        if (cnt == (longint'(1) << de)) begin
          r = (acc <<< (16 - de)) + longint'($signed(bias));
          if (r > 64'sd2147483647) r = 64'sd2147483647;
          if (r < -64'sd2147483648) r = -64'sd2147483648;
          ed = r[31:0];
          ev = 1;
          acc = 0;
          cnt = 0;
        end
      end
      prev_b = int'(tap_exp);
      prev_d = int'(dec_exp);
    end
  end

  // compare on every clock, midway between drive time and the next edge
  always @(negedge clk) begin
    #5;
    if (rst_n && !finished) begin
      automatic bit er = model_ready();
      total++;
      if (m_valid !== ev || s_ready !== er ||
          (ev && {m_data_hi, m_data_lo} !== ed)) begin
        bad++;
        $display("FAIL %s: m_valid=%0b exp=%0b data=%h exp=%h s_ready=%0b exp=%0b",
                 cur_req, m_valid, ev, {m_data_hi, m_data_lo}, ed, s_ready, er);
      end
    end
  end

  task automatic set_ctrl(input int b, input int d, input logic [31:0] off);
    @(negedge clk); #2;
    tap_exp = 3'(b); dec_exp = 5'(d); bias = off;
    s_valid = 1'b0; m_ready = 1'b1;
  endtask

  // mode: 0 random, 1 +full, 2 -full, 3 ramp, 4 impulse
  task automatic run(input int n, input int mode, input int vprob, input int rprob);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #2;
      s_valid = (($urandom % 100) < vprob);
      m_ready = (($urandom % 100) < rprob);
      case (mode)
        0: s_sample = 16'($urandom);
        1: s_sample = 16'h7FFF;
        2: s_sample = 16'h8000;
        3: s_sample = 16'(i * 37 - 3000);
        default: s_sample = (i == 0) ? 16'd1000 : 16'd0;
      endcase
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      bad++; total++;
      $display("FAIL watchdog: %s run did not end, actual=hung expected=done", cur_req);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    total++;
    if (m_valid !== 1'b0) begin
      bad++;
      $display("FAIL R1: m_valid=%0b expected=0 in reset", m_valid);
    end
    #2 rst_n = 1'b1;
    @(negedge clk); #6;
    total++;
    if (m_valid !== 1'b0 || s_ready !== 1'b1) begin
      bad++;
      $display("FAIL R1: m_valid=%0b s_ready=%0b expected 0/1", m_valid, s_ready);
    end
    cur_req = "R2";  set_ctrl(0, 0, 32'h0);       run(40, 0, 100, 100);
    cur_req = "R3";  set_ctrl(2, 0, 32'h0);       run(40, 4, 100, 100);
                     set_ctrl(4, 0, 32'h0);       run(80, 0, 100, 100);
                     set_ctrl(6, 0, 32'h0);       run(160, 3, 100, 100);
    cur_req = "R2";  set_ctrl(7, 0, 32'h0);       run(150, 0, 100, 100);
    cur_req = "R4";  set_ctrl(0, 3, 32'h0);       run(100, 0, 100, 100);
    cur_req = "R9";  set_ctrl(1, 2, 32'h0);       run(200, 0, 40, 100);
    cur_req = "R5";  set_ctrl(3, 5, 32'h0);       run(300, 0, 100, 100);
                     set_ctrl(0, 1, 32'h00018000); run(40, 3, 100, 100);
    cur_req = "R6";  set_ctrl(0, 0, 32'h7FFF0000); run(20, 1, 100, 100);
                     set_ctrl(0, 0, 32'h80000000); run(20, 2, 100, 100);
                     set_ctrl(1, 2, 32'hFFFF8000); run(60, 0, 100, 100);
    cur_req = "R7";  set_ctrl(2, 4, 32'h0);       run(10, 0, 100, 100);
                     set_ctrl(3, 4, 32'h0);       run(40, 0, 100, 100);
                     set_ctrl(3, 1, 32'h0);       run(20, 0, 100, 100);
                     set_ctrl(5, 1, 32'h0);       run(3, 0, 100, 100);
    cur_req = "R8";  set_ctrl(1, 1, 32'h12345678); run(300, 0, 80, 30);
                     set_ctrl(0, 0, 32'h0);       run(100, 0, 100, 20);
    cur_req = "R4";  set_ctrl(0, 17, 32'h0);      run(65600, 0, 100, 100);
    set_ctrl(0, 17, 32'h0);
    repeat (3) @(negedge clk);
    #7;
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule